// File: doc/BRIEF.md
# MESI Snooping Cache Coherence Controller

This block keeps one direct-mapped, write-back cache coherent with its peers on a shared snooping bus. Every line carries one of four coherence states: Modified (dirty, only copy), Exclusive (clean, only copy), Shared (clean, other copies may exist) or Invalid. Processor reads and writes are served from the local copy when its state permits. Otherwise the controller becomes bus master, waits for a grant and issues one of four line commands: read, write-back, read-for-ownership or invalidate.

The bus serialises all traffic, and the controller watches every transaction issued by the other agents. Snoop lookups use a second copy of the tag array, so a snoop never waits for a processor lookup. The snoop reply is combinational in the snoop cycle. It raises a shared flag when the line is held. It raises a dirty flag, and puts the line's data on the snoop data lines, when the copy is Modified. The line's state changes at the clock edge that ends the snoop.

A snoop can change a line while a processor request is waiting for a grant. The pending request is then re-evaluated against the new state, so the bus only ever sees a command that is valid for the line as it is now. Addresses are line addresses. The low index bits select the line and the upper bits form the tag. A line is one data word.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, cpu_ready_o and bus_req_o are low, and a snoop to any address gets snp_shared_o and snp_dirty_o low.
- R2: A read miss issues read-line (bus_cmd_o = 0) at the requested address and returns bus_rdata_i. The line fills Exclusive when bus_shared_i is low during the grant cycle and Shared when it is high.
- R3: A write miss issues read-for-ownership (bus_cmd_o = 2) at the requested address. The line fills Modified, holding the write data.
- R4: A write hit on an Exclusive or Modified line completes with no bus transaction and leaves the line Modified with the new data.
- R5: A write hit on a Shared line issues invalidate (bus_cmd_o = 3) at the line address, then holds the line Modified with the new data.
- R6: A miss whose index holds a Modified line with another tag first issues write-back (bus_cmd_o = 1) carrying the victim address and data. It then issues the refill command.
- R7: A snooped read-line (snp_cmd_i = 0) that hits raises snp_shared_o and leaves the line Shared. If the line was Modified it also raises snp_dirty_o with the line data on snp_data_o.
- R8: A snooped read-for-ownership (2) or invalidate (3) that hits raises snp_shared_o and makes the line Invalid. A Modified copy supplies its data with snp_dirty_o in that same cycle.
- R9: A snooped write-back (snp_cmd_i = 1), or a snoop whose address is not held, raises neither snoop output and changes no line state.
- R10: If a snoop invalidates the line while its invalidate request awaits the grant, the request becomes read-for-ownership. If a snoop leaves a pending victim no longer Modified, the write-back is dropped and only the refill is issued.
- R11: bus_req_o stays high until granted. Each access ends with a one-cycle cpu_ready_o pulse, and a read hit returns the line data without bus traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | One-cycle access request |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Line address of the access |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | Access complete pulse |
| cpu_rdata_o | output | DATA_W | Read data, valid with cpu_ready_o |
| bus_req_o | output | 1 | Bus mastership request |
| bus_gnt_i | input | 1 | Grant; the transaction completes in this cycle |
| bus_cmd_o | output | 2 | 0 read, 1 write-back, 2 read-for-ownership, 3 invalidate |
| bus_addr_o | output | ADDR_W | Transaction line address |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_rdata_i | input | DATA_W | Fill data, valid in the grant cycle |
| bus_shared_i | input | 1 | Another cache holds the line, valid in the grant cycle |
| snp_valid_i | input | 1 | Another agent's transaction is on the bus |
| snp_cmd_i | input | 2 | Snooped command, same encoding as bus_cmd_o |
| snp_addr_i | input | ADDR_W | Snooped line address |
| snp_shared_o | output | 1 | This cache holds the snooped line |
| snp_dirty_o | output | 1 | This cache supplies dirty data |
| snp_data_o | output | DATA_W | Supplied dirty data |

## Verification
The hardest situations to reach are the races of R10, where another agent's transaction lands in the window between a request and its grant. The bench opens that window by holding the grant back. It waits until the controller shows an invalidate or write-back request on the bus, injects the conflicting snoop, and then releases the grant. It then checks which command is actually transacted and which state the line ends in. Intermediate states are read out through the normal ports, either by the bus traffic that a later write causes or by the reply to a later snoop.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_state_e;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_WB  = 2'd1,
    CMD_RDX = 2'd2,
    CMD_INV = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    F_IDLE = 3'd0,
    F_LOOK = 3'd1,
    F_WB   = 3'd2,
    F_UPG  = 3'd3,
    F_FILL = 3'd4
  } fsm_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  output mesi_state_e       cpu_state_o,
  output logic [TAG_W-1:0]  cpu_tag_o,
  output logic [DATA_W-1:0] cpu_data_o,
  input  logic              cpu_st_we_i,
  input  mesi_state_e       cpu_st_i,
  input  logic              cpu_fill_we_i,
  input  logic [TAG_W-1:0]  cpu_tag_i,
  input  logic              cpu_dat_we_i,
  input  logic [DATA_W-1:0] cpu_dat_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  output mesi_state_e       snp_state_o,
  output logic [TAG_W-1:0]  snp_tag_o,
  output logic [DATA_W-1:0] snp_data_o,
  input  logic              snp_st_we_i,
  input  mesi_state_e       snp_st_i
);
  mesi_state_e       st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [TAG_W-1:0]  dtag_q [LINES];  // snoop-side tag copy
  logic [DATA_W-1:0] dat_q  [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= ST_I;
        tag_q[i]  <= '0;
        dtag_q[i] <= '0;
        dat_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        // snoop update wins on a shared index
        if (snp_st_we_i && snp_idx_i == IDX_W'(i))
          st_q[i] <= snp_st_i;
        else if (cpu_st_we_i && cpu_idx_i == IDX_W'(i))
          st_q[i] <= cpu_st_i;
        if (cpu_fill_we_i && cpu_idx_i == IDX_W'(i)) begin
          tag_q[i]  <= cpu_tag_i;
          dtag_q[i] <= cpu_tag_i;
        end
        if (cpu_dat_we_i && cpu_idx_i == IDX_W'(i))
          dat_q[i] <= cpu_dat_i;
      end
    end
  end

  assign cpu_state_o = st_q[cpu_idx_i];
  assign cpu_tag_o   = tag_q[cpu_idx_i];
  assign cpu_data_o  = dat_q[cpu_idx_i];
  assign snp_state_o = st_q[snp_idx_i];
  assign snp_tag_o   = dtag_q[snp_idx_i];
  assign snp_data_o  = dat_q[snp_idx_i];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic              snp_valid_i,
  input  bus_cmd_e          snp_cmd_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  mesi_state_e       line_state_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              shared_o,
  output logic              dirty_o,
  output logic [DATA_W-1:0] data_o,
  output logic              st_we_o,
  output mesi_state_e       st_o
);
  logic hit;

  // write-backs from others never touch our copy
  assign hit      = snp_valid_i && (snp_cmd_i != CMD_WB) &&
                    (line_state_i != ST_I) && (line_tag_i == snp_tag_i);
  assign shared_o = hit;
  assign dirty_o  = hit && (line_state_i == ST_M);
  assign data_o   = dirty_o ? line_data_i : '0;
  assign st_we_o  = hit;
  assign st_o     = (snp_cmd_i == CMD_RD) ? ST_S : ST_I;
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 13,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cpu_req_i,
  input  logic                    cpu_we_i,
  input  logic [TAG_W-1:0]        cpu_tag_i,
  input  logic [IDX_W-1:0]        cpu_idx_i,
  input  logic [DATA_W-1:0]       cpu_wdata_i,
  output logic                    cpu_ready_o,
  output logic [DATA_W-1:0]       cpu_rdata_o,
  output logic [IDX_W-1:0]        idx_o,
  input  mesi_state_e             line_state_i,
  input  logic [TAG_W-1:0]        line_tag_i,
  input  logic [DATA_W-1:0]       line_data_i,
  input  logic                    snp_block_i,
  output logic                    st_we_o,
  output mesi_state_e             st_o,
  output logic                    fill_we_o,
  output logic [TAG_W-1:0]        fill_tag_o,
  output logic                    dat_we_o,
  output logic [DATA_W-1:0]       dat_o,
  output logic                    bus_req_o,
  input  logic                    bus_gnt_i,
  output bus_cmd_e                bus_cmd_o,
  output logic [TAG_W+IDX_W-1:0]  bus_addr_o,
  output logic [DATA_W-1:0]       bus_wdata_o,
  input  logic [DATA_W-1:0]       bus_rdata_i,
  input  logic                    bus_shared_i
);
  fsm_e              st_q, st_d;
  logic              we_q;
  logic [TAG_W-1:0]  rtag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rdy_q, rdy_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              hit, fill_go;

  assign hit        = (line_state_i != ST_I) && (line_tag_i == rtag_q);
  assign idx_o      = idx_q;
  assign fill_tag_o = rtag_q;

  always_comb begin
    st_d        = st_q;
    rdy_d       = 1'b0;
    rdata_d     = rdata_q;
    st_we_o     = 1'b0;
    st_o        = ST_I;
    fill_we_o   = 1'b0;
    dat_we_o    = 1'b0;
    dat_o       = wdata_q;
    bus_req_o   = 1'b0;
    bus_cmd_o   = CMD_RD;
    bus_addr_o  = {rtag_q, idx_q};
    bus_wdata_o = '0;
    fill_go     = 1'b0;
    unique case (st_q)
      F_IDLE: if (cpu_req_i) st_d = F_LOOK;
      F_LOOK: begin
        // a snoop on this index this cycle takes precedence
        if (!snp_block_i) begin
          if (hit) begin
            if (!we_q) begin
              rdy_d   = 1'b1;
              rdata_d = line_data_i;
              st_d    = F_IDLE;
            end else if (line_state_i == ST_S) begin
              st_d = F_UPG;
            end else begin
              st_we_o  = 1'b1;
              st_o     = ST_M;
              dat_we_o = 1'b1;
              rdy_d    = 1'b1;
              st_d     = F_IDLE;
            end
          end else if (line_state_i == ST_M) begin
            st_d = F_WB;
          end else begin
            st_d = F_FILL;
          end
        end
      end
      F_WB: begin
        if (line_state_i == ST_M) begin
          bus_req_o   = 1'b1;
          bus_cmd_o   = CMD_WB;
          bus_addr_o  = {line_tag_i, idx_q};
          bus_wdata_o = line_data_i;
          if (bus_gnt_i) st_d = F_FILL;
        end else begin
          fill_go = 1'b1;  // victim lost by a snoop: skip write-back
        end
      end
      F_UPG: begin
        if (hit && line_state_i == ST_S) begin
          bus_req_o = 1'b1;
          bus_cmd_o = CMD_INV;
          if (bus_gnt_i) begin
            st_we_o  = 1'b1;
            st_o     = ST_M;
            dat_we_o = 1'b1;
            rdy_d    = 1'b1;
            st_d     = F_IDLE;
          end
        end else begin
          fill_go = 1'b1;  // copy invalidated: fetch with ownership
        end
      end
      F_FILL: fill_go = 1'b1;
      default: st_d = F_IDLE;
    endcase

    if (fill_go) begin
      bus_req_o  = 1'b1;
      bus_cmd_o  = we_q ? CMD_RDX : CMD_RD;
      bus_addr_o = {rtag_q, idx_q};
      if (bus_gnt_i) begin
        st_we_o   = 1'b1;
        st_o      = we_q ? ST_M : (bus_shared_i ? ST_S : ST_E);
        fill_we_o = 1'b1;
        dat_we_o  = 1'b1;
        dat_o     = we_q ? wdata_q : bus_rdata_i;
        rdy_d     = 1'b1;
        rdata_d   = bus_rdata_i;
        st_d      = F_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= F_IDLE;
      we_q    <= 1'b0;
      rtag_q  <= '0;
      idx_q   <= '0;
      wdata_q <= '0;
      rdy_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      rdy_q   <= rdy_d;
      rdata_q <= rdata_d;
      if (st_q == F_IDLE && cpu_req_i) begin
        we_q    <= cpu_we_i;
        rtag_q  <= cpu_tag_i;
        idx_q   <= cpu_idx_i;
        wdata_q <= cpu_wdata_i;
      end
    end
  end

  assign cpu_ready_o = rdy_q;
  assign cpu_rdata_o = rdata_q;
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_shared_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_dirty_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  req_idx;
  mesi_state_e       cpu_state, snp_state, cpu_st, snp_st;
  logic [TAG_W-1:0]  cpu_tag, snp_tag, fill_tag;
  logic [DATA_W-1:0] cpu_data, snp_line_data, dat_w;
  logic              st_we, fill_we, dat_we, snp_st_we, snp_block;
  bus_cmd_e          cmd;

  assign snp_block = snp_valid_i && (snp_addr_i[IDX_W-1:0] == req_idx);
  assign bus_cmd_o = cmd;

  mesi_line_store #(
    .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_idx_i    (req_idx),
    .cpu_state_o  (cpu_state),
    .cpu_tag_o    (cpu_tag),
    .cpu_data_o   (cpu_data),
    .cpu_st_we_i  (st_we),
    .cpu_st_i     (cpu_st),
    .cpu_fill_we_i(fill_we),
    .cpu_tag_i    (fill_tag),
    .cpu_dat_we_i (dat_we),
    .cpu_dat_i    (dat_w),
    .snp_idx_i    (snp_addr_i[IDX_W-1:0]),
    .snp_state_o  (snp_state),
    .snp_tag_o    (snp_tag),
    .snp_data_o   (snp_line_data),
    .snp_st_we_i  (snp_st_we),
    .snp_st_i     (snp_st)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid_i (snp_valid_i),
    .snp_cmd_i   (bus_cmd_e'(snp_cmd_i)),
    .snp_tag_i   (snp_addr_i[ADDR_W-1:IDX_W]),
    .line_state_i(snp_state),
    .line_tag_i  (snp_tag),
    .line_data_i (snp_line_data),
    .shared_o    (snp_shared_o),
    .dirty_o     (snp_dirty_o),
    .data_o      (snp_data_o),
    .st_we_o     (snp_st_we),
    .st_o        (snp_st)
  );

  mesi_req_fsm #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_tag_i   (cpu_addr_i[ADDR_W-1:IDX_W]),
    .cpu_idx_i   (cpu_addr_i[IDX_W-1:0]),
    .cpu_wdata_i (cpu_wdata_i),
    .cpu_ready_o (cpu_ready_o),
    .cpu_rdata_o (cpu_rdata_o),
    .idx_o       (req_idx),
    .line_state_i(cpu_state),
    .line_tag_i  (cpu_tag),
    .line_data_i (cpu_data),
    .snp_block_i (snp_block),
    .st_we_o     (st_we),
    .st_o        (cpu_st),
    .fill_we_o   (fill_we),
    .fill_tag_o  (fill_tag),
    .dat_we_o    (dat_we),
    .dat_o       (dat_w),
    .bus_req_o   (bus_req_o),
    .bus_gnt_i   (bus_gnt_i),
    .bus_cmd_o   (cmd),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_shared_i(bus_shared_i)
  );
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cpu_ready_o,
  input logic       bus_req_o,
  input logic       bus_gnt_i,
  input logic [1:0] bus_cmd_o,
  input logic       snp_valid_i,
  input logic [1:0] snp_cmd_i,
  input logic       snp_shared_o,
  input logic       snp_dirty_o
);
  // R1
  idle_snoop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i |-> (!snp_shared_o && !snp_dirty_o));

  // R7
  dirty_has_shared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_dirty_o |-> snp_shared_o);

  // R9
  wb_snoop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == 2'd1) |-> (!snp_shared_o && !snp_dirty_o));

  // R11
  req_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> bus_req_o);

  // R11
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |=> !cpu_ready_o);

  // R3
  grant_completes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && bus_cmd_o != 2'd1) |=> cpu_ready_o);
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk u_chk (.*);

// File: tb/tb_mesi_snoop_ctrl.sv
module tb_mesi_snoop_ctrl;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic          cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready_o;
  logic [DW-1:0] cpu_rdata_o;
  logic          bus_req_o, bus_gnt = 0, bus_shared = 0;
  logic [1:0]    bus_cmd_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o, bus_rdata = '0;
  logic          snp_valid = 0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_shared_o, snp_dirty_o;
  logic [DW-1:0] snp_data_o;

  mesi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(8)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready_o), .cpu_rdata_o(cpu_rdata_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata), .bus_shared_i(bus_shared),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_shared_o(snp_shared_o), .snp_dirty_o(snp_dirty_o), .snp_data_o(snp_data_o)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk_eq(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory and other-agent model
  logic [DW-1:0] mem [int];
  function automatic logic [DW-1:0] mem_rd(logic [AW-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : (32'hA500_0000 | DW'(a));
  endfunction

  typedef struct { logic [1:0] cmd; logic [AW-1:0] addr; logic [DW-1:0] data; } bus_t;
  bus_t bus_log[$];
  bit   hold_gnt = 0;
  bit   oth_shared = 0;

  initial begin
    forever begin
      @(negedge clk);
      bus_gnt = 0;
      if (rst_ni && bus_req_o && !hold_gnt) begin
        bus_gnt    = 1;
        bus_shared = oth_shared;
        bus_rdata  = mem_rd(bus_addr_o);
        bus_log.push_back('{bus_cmd_o, bus_addr_o, bus_wdata_o});
        if (bus_cmd_o == 2'd1) mem[int'(bus_addr_o)] = bus_wdata_o;
      end
    end
  end

  // scoreboard
  typedef struct { bit rd; logic [DW-1:0] data; string req; } exp_t;
  exp_t sb[$];
  int   done_cnt = 0;

  always @(negedge clk) begin : monitor
    exp_t e;
    if (rst_ni && cpu_ready_o) begin
      if (sb.size() == 0) chk_eq("R11 unexpected ready", 1, 0);
      else begin
        e = sb.pop_front();
        if (e.rd) chk_eq(e.req, cpu_rdata_o, e.data);
      end
      done_cnt++;
    end
  end

  task automatic cpu_op(bit we, logic [AW-1:0] a, logic [DW-1:0] wd, bit sh,
                        string req, logic [DW-1:0] exp_rd);
    int d0;
    oth_shared = sh;
    bus_log.delete();
    sb.push_back('{!we, exp_rd, req});
    d0 = done_cnt;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 0;
    while (done_cnt == d0) @(negedge clk);
  endtask

  task automatic snoop(logic [1:0] cmd, logic [AW-1:0] a,
                       output logic sh, output logic dt, output logic [DW-1:0] d);
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = a;
    #1;
    sh = snp_shared_o; dt = snp_dirty_o; d = snp_data_o;
    if (dt) mem[int'(a)] = d;
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic chk_bus(int i, logic [1:0] cmd, logic [AW-1:0] a, string req);
    if (bus_log.size() <= i) chk_eq(req, DW'(bus_log.size()), DW'(i + 1));
    else begin
      chk_eq(req, DW'(bus_log[i].cmd), DW'(cmd));
      chk_eq(req, DW'(bus_log[i].addr), DW'(a));
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic sh, dt;
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk_eq("R1 ready", DW'(cpu_ready_o), 0);
    chk_eq("R1 bus_req", DW'(bus_req_o), 0);
    snoop(2'd0, 16'h0010, sh, dt, d);
    chk_eq("R1 snoop shared", DW'(sh), 0);
    chk_eq("R1 snoop dirty", DW'(dt), 0);

    // R2 read miss, no sharer -> Exclusive
    cpu_op(0, 16'h0010, 0, 0, "R2 read miss data", 32'hA500_0010);
    chk_eq("R2 bus count", DW'(bus_log.size()), 1);
    chk_bus(0, 2'd0, 16'h0010, "R2 read cmd");
    // R4 write hit Exclusive is silent
    cpu_op(1, 16'h0010, 32'h1111, 0, "R4 write E", 0);
    chk_eq("R4 silent E", DW'(bus_log.size()), 0);
    // R7 snooped read of Modified
    snoop(2'd0, 16'h0010, sh, dt, d);
    chk_eq("R7 shared", DW'(sh), 1);
    chk_eq("R7 dirty", DW'(dt), 1);
    chk_eq("R7 data", d, 32'h1111);
    // R5 write hit Shared
    cpu_op(1, 16'h0010, 32'h2222, 0, "R5 write S", 0);
    chk_eq("R5 bus count", DW'(bus_log.size()), 1);
    chk_bus(0, 2'd3, 16'h0010, "R5 invalidate cmd");
    // R8 snooped read-for-ownership of Modified
    snoop(2'd2, 16'h0010, sh, dt, d);
    chk_eq("R8 dirty", DW'(dt), 1);
    chk_eq("R8 data", d, 32'h2222);
    snoop(2'd0, 16'h0010, sh, dt, d);
    chk_eq("R8 now invalid", DW'(sh), 0);
    // R2 read miss with sharer -> Shared
    cpu_op(0, 16'h0010, 0, 1, "R2 shared fill data", 32'h2222);
    cpu_op(1, 16'h0010, 32'h3333, 0, "R2 write after shared fill", 0);
    chk_bus(0, 2'd3, 16'h0010, "R2 fill was Shared");
    // R6 eviction of Modified
    cpu_op(0, 16'h0018, 0, 0, "R6 refill data", 32'hA500_0018);
    chk_eq("R6 bus count", DW'(bus_log.size()), 2);
    chk_bus(0, 2'd1, 16'h0010, "R6 writeback first");
    chk_eq("R6 writeback data", bus_log[0].data, 32'h3333);
    chk_bus(1, 2'd0, 16'h0018, "R6 refill second");
    // R11 read hit
    cpu_op(0, 16'h0018, 0, 0, "R11 read hit data", 32'hA500_0018);
    chk_eq("R11 hit no bus", DW'(bus_log.size()), 0);
    cpu_op(1, 16'h0018, 32'h4444, 0, "R4 write E2", 0);
    cpu_op(1, 16'h0018, 32'h5555, 0, "R4 write M", 0);
    chk_eq("R4 silent M", DW'(bus_log.size()), 0);
    // R3 write miss
    cpu_op(1, 16'h0021, 32'h6666, 0, "R3 write miss", 0);
    chk_bus(0, 2'd2, 16'h0021, "R3 rfo cmd");
    snoop(2'd0, 16'h0021, sh, dt, d);
    chk_eq("R3 filled Modified", DW'(dt), 1);
    chk_eq("R3 merged data", d, 32'h6666);
    // R8 invalidate snoop on Shared
    snoop(2'd3, 16'h0021, sh, dt, d);
    chk_eq("R8 inv shared", DW'(sh), 1);
    chk_eq("R8 inv clean", DW'(dt), 0);
    snoop(2'd0, 16'h0021, sh, dt, d);
    chk_eq("R8 inv result", DW'(sh), 0);
    // R9 miss and write-back snoops
    snoop(2'd0, 16'h0121, sh, dt, d);
    chk_eq("R9 tag miss", DW'(sh | dt), 0);
    snoop(2'd1, 16'h0018, sh, dt, d);
    chk_eq("R9 wb snoop", DW'(sh | dt), 0);
    cpu_op(1, 16'h0018, 32'h7777, 0, "R9 still M", 0);
    chk_eq("R9 state kept", DW'(bus_log.size()), 0);

    // R10 upgrade race
    cpu_op(0, 16'h0002, 0, 1, "R10 prep read", 32'hA500_0002);
    hold_gnt = 1;
    fork
      cpu_op(1, 16'h0002, 32'h8888, 0, "R10 upgrade race", 0);
      begin
        do @(negedge clk); while (!(bus_req_o && bus_cmd_o == 2'd3));
        snoop(2'd2, 16'h0002, sh, dt, d);
        hold_gnt = 0;
      end
    join
    chk_eq("R10 upg bus count", DW'(bus_log.size()), 1);
    chk_bus(0, 2'd2, 16'h0002, "R10 became rfo");
    snoop(2'd0, 16'h0002, sh, dt, d);
    chk_eq("R10 upg data", d, 32'h8888);

    // R10 write-back race
    cpu_op(1, 16'h0003, 32'h9999, 0, "R10 prep write", 0);
    hold_gnt = 1;
    fork
      cpu_op(0, 16'h000B, 0, 0, "R10 wb race data", 32'hA500_000B);
      begin
        do @(negedge clk); while (!(bus_req_o && bus_cmd_o == 2'd1));
        snoop(2'd0, 16'h0003, sh, dt, d);
        chk_eq("R10 victim supplied", DW'(dt), 1);
        hold_gnt = 0;
      end
    join
    chk_eq("R10 wb dropped", DW'(bus_log.size()), 1);
    chk_bus(0, 2'd0, 16'h000B, "R10 refill only");
    chk_eq("R10 mem via snoop", mem_rd(16'h0003), 32'h9999);

    repeat (4) @(negedge clk);
    chk_eq("R11 scoreboard drained", DW'(sb.size()), 0);
    finish_run();
  end
endmodule